// File: doc/BRIEF.md
# Match-Register System Timer with Watchdog

This block is a system timer that sits on a simple register bus. A 32-bit up-counter advances by one on each cycle where the tick-enable strobe is high. Software can also load the counter with any value, and counting then continues from that value. Four 32-bit compare registers are checked against the value the counter is about to take. When a compare register matches and its channel is enabled, the channel latches a sticky flag, and that flag drives the channel's interrupt line. Software clears a flag by writing a one to its bit in the flag register.

Compare channel 3 also acts as a one-shot watchdog. If bit 0 of the watchdog arm register is set when channel 3 matches, the block raises a reset request for one cycle and clears the arm register. This happens whether or not channel 3's interrupt is enabled. The clock that produces the tick strobe and the bridge to the system bus are outside this block.

Top module: `systimer`

## Requirements
- R1: After a synchronous reset, every register reads zero: the counter, the four compare registers, the flag register, the interrupt mask and the watchdog arm register. All four `irq` lines and `reset_req` are low.
- R2: On a cycle with `tick` high and no counter write, the counter at offset 0x10 increases by one and wraps from 0xFFFFFFFF to 0. With `tick` low and no counter write, it holds its value.
- R3: A bus write to offset 0x10 loads the counter with `bus_wdata` on that edge. The load wins over a `tick` in the same cycle, and that cycle raises no match.
- R4: Compare channel n sits at offset 4·n (0x00, 0x04, 0x08, 0x0C) and reads back the full 32 bits written. A match occurs on a ticking cycle without a counter load where the counter plus one equals compare register n. If mask bit n is set, flag bit n goes high on the same edge that the counter takes the matching value, and `irq[n]` equals flag bit n.
- R5: A match on a channel whose mask bit is clear leaves its flag bit and `irq` line unchanged.
- R6: The flag register at offset 0x14 reads in bits 3:0 (bit n is channel n; upper bits read zero). A write clears exactly those flag bits that are set both in `bus_wdata` and in the flag register. Zero bits have no effect. A new match in the same cycle keeps its bit set.
- R7: The interrupt mask at offset 0x1C keeps only bits 11:0 of a write and reads zero above them. Bit n of the mask enables channel n.
- R8: The watchdog arm register at offset 0x18 stores the full 32-bit write. When channel 3 matches while bit 0 of this register is set, `reset_req` is high for exactly one cycle (on the same edge as the match) and the register is cleared, whatever the mask holds. Clearing it wins over a write in the same cycle.
- R9: The comparison is a full 32-bit equality, so a compare value below the loaded counter value matches after the counter wraps.
- R10: Any offset other than the eight listed, including misaligned ones, reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable strobe at the timer base rate |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe for the current offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset (combinational) |
| irq | output | 4 | Per-channel interrupt lines, one per compare channel |
| reset_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
The compare logic is tried under several patterns, each telling apart a different kind of fault:
- Steady ticking into a match on an enabled channel separates a correct compare on the next counter value from an off-by-one compare on the current value.
- Ticks with gaps and a load during a tick show whether the load has priority.
- A match on a masked channel and a match on channel 3 with the mask clear show that flag setting and the watchdog are gated separately.
- Loading near the top of the range and matching a small value checks the wrap.
- Clears with mixed one and zero bits, a clear in the same cycle as a match, and writes to unused offsets check that writes reach only the bits they name.

// File: rtl/systimer_pkg.sv
package systimer_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int NUM_CH   = 4;
    localparam int MASK_W   = 12;
    localparam int WDOG_CH  = 3;
    localparam int CH_IDX_W = $clog2(NUM_CH);

    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FLAGS = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WDOG  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h1C;

    typedef struct packed {
        logic                cmp;
        logic [CH_IDX_W-1:0] ch;
        logic                count;
        logic                flags;
        logic                wdog;
        logic                mask;
    } regsel_t;

    function automatic regsel_t decode_addr(input logic [ADDR_W-1:0] a);
        regsel_t s;
        s       = '0;
        s.ch    = a[CH_IDX_W+1:2];
        s.cmp   = (a[1:0] == 2'b00) && (a < ADDR_W'(NUM_CH * 4));
        s.count = (a == OFS_COUNT);
        s.flags = (a == OFS_FLAGS);
        s.wdog  = (a == OFS_WDOG);
        s.mask  = (a == OFS_MASK);
        return s;
    endfunction

endpackage

// File: rtl/systimer_counter.sv
module systimer_counter #(
    parameter int W = systimer_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic [W-1:0] count_inc
);
    logic [W-1:0] cnt_q;

    assign count_inc = cnt_q + W'(1);
    assign count     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (tick) cnt_q <= count_inc;
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> (cnt_q == $past(cnt_q) + W'(1)));
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));
    assert_count_load_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/systimer_match.sv
module systimer_match #(
    parameter int W  = systimer_pkg::DATA_W,
    parameter int NC = systimer_pkg::NUM_CH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 advance,
    input  logic [W-1:0]         next_count,
    input  logic [NC-1:0][W-1:0] cmp_vals,
    input  logic [NC-1:0]        enables,
    input  logic [NC-1:0]        clr_req,
    output logic [NC-1:0]        hit,
    output logic [NC-1:0]        flags
);
    logic [NC-1:0] flag_q;
    logic [NC-1:0] clr_eff;

    assign clr_eff = clr_req & flag_q;
    assign flags   = flag_q;

    for (genvar i = 0; i < NC; i++) begin : g_ch
        assign hit[i] = advance && (next_count == cmp_vals[i]);

        always_ff @(posedge clk) begin
            if (rst)
                flag_q[i] <= 1'b0;
            else if (hit[i] && enables[i])
                flag_q[i] <= 1'b1;
            else if (clr_eff[i])
                flag_q[i] <= 1'b0;
        end

        assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && enables[i]) |=> flag_q[i]);
        assert_masked_keep_R5: assert property (@(posedge clk) disable iff (rst)
            (!enables[i] && !clr_req[i]) |=> $stable(flag_q[i]));
        assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
            (clr_req[i] && !(hit[i] && enables[i])) |=> !flag_q[i]);
    end

endmodule

// File: rtl/systimer_watchdog.sv
module systimer_watchdog #(
    parameter int W = systimer_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wd_hit,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] arm,
    output logic         reset_req
);
    logic [W-1:0] arm_q;
    logic         req_q;
    logic         fire;

    assign fire      = wd_hit && arm_q[0];
    assign arm       = arm_q;
    assign reset_req = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= fire;
            if (fire)    arm_q <= '0;
            else if (wr) arm_q <= wr_data;
        end
    end

    assert_pulse_once_R8: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);
    assert_disarm_R8: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (arm_q == '0));
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        !wd_hit |=> !reset_req);

endmodule

// File: rtl/systimer.sv
module systimer
    import systimer_pkg::*;
#(
    parameter int DW = systimer_pkg::DATA_W,
    parameter int AW = systimer_pkg::ADDR_W,
    parameter int NC = systimer_pkg::NUM_CH,
    parameter int MW = systimer_pkg::MASK_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [NC-1:0] irq,
    output logic          reset_req
);
    regsel_t              sel;
    logic [NC-1:0][DW-1:0] cmp_q;
    logic [MW-1:0]        mask_q;
    logic [DW-1:0]        count, count_inc, arm;
    logic [NC-1:0]        hit, flags, clr_req;
    logic                 load;

    assign sel     = decode_addr(bus_addr);
    assign load    = bus_we && sel.count;
    assign clr_req = (bus_we && sel.flags) ? bus_wdata[NC-1:0] : '0;
    assign irq     = flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            mask_q <= '0;
        end else if (bus_we) begin
            if (sel.cmp)  cmp_q[sel.ch] <= bus_wdata;
            if (sel.mask) mask_q        <= bus_wdata[MW-1:0];
        end
    end

    systimer_counter #(.W(DW)) u_counter (
        .clk(clk), .rst(rst), .tick(tick), .load(load),
        .load_val(bus_wdata), .count(count), .count_inc(count_inc)
    );

    systimer_match #(.W(DW), .NC(NC)) u_match (
        .clk(clk), .rst(rst), .advance(tick && !load),
        .next_count(count_inc), .cmp_vals(cmp_q),
        .enables(mask_q[NC-1:0]), .clr_req(clr_req),
        .hit(hit), .flags(flags)
    );

    systimer_watchdog #(.W(DW)) u_wdog (
        .clk(clk), .rst(rst), .wd_hit(hit[WDOG_CH]),
        .wr(bus_we && sel.wdog), .wr_data(bus_wdata),
        .arm(arm), .reset_req(reset_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel.cmp)   bus_rdata = cmp_q[sel.ch];
        if (sel.count) bus_rdata = count;
        if (sel.flags) bus_rdata = DW'(flags);
        if (sel.wdog)  bus_rdata = arm;
        if (sel.mask)  bus_rdata = DW'(mask_q);
    end

    assert_irq_follows_R4: assert property (@(posedge clk) disable iff (rst)
        (load) |=> (irq == $past(irq) & ~($past(clr_req) & $past(irq))));
    assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !sel.cmp && !sel.count && !sel.flags && !sel.wdog && !sel.mask && !tick)
        |=> ($stable(cmp_q) && $stable(mask_q) && $stable(count) && $stable(irq)));

endmodule

// File: tb/systimer_test.sv
module systimer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        reset_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] r_cnt;
    logic [31:0] r_cmp [4];
    logic [3:0]  r_flag;
    logic [11:0] r_mask;
    logic [31:0] r_arm;
    logic        r_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    systimer uut (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .reset_req(reset_req)
    );

    function automatic logic [31:0] ref_read(input logic [7:0] a);
        case (a)
            8'h00: return r_cmp[0];
            8'h04: return r_cmp[1];
            8'h08: return r_cmp[2];
            8'h0C: return r_cmp[3];
            8'h10: return r_cnt;
            8'h14: return {28'd0, r_flag};
            8'h18: return r_arm;
            8'h1C: return {20'd0, r_mask};
            default: return 32'd0;
        endcase
    endfunction

    task automatic ref_update();
        logic [3:0]  m;
        logic [3:0]  clr;
        logic        ld;
        logic        fire;
        if (rst) begin
            r_cnt = 0; r_flag = 0; r_mask = 0; r_arm = 0; r_req = 0;
            for (int k = 0; k < 4; k++) r_cmp[k] = 0;
            return;
        end
        ld = bus_we && bus_addr == 8'h10;
        m = '0;
        for (int k = 0; k < 4; k++)
            if (tick && !ld && (r_cnt + 32'd1) == r_cmp[k]) m[k] = 1'b1;
        clr = (bus_we && bus_addr == 8'h14) ? (bus_wdata[3:0] & r_flag) : 4'd0;
        fire = m[3] && r_arm[0];
        r_req = fire;
        if (fire) r_arm = 0;
        else if (bus_we && bus_addr == 8'h18) r_arm = bus_wdata;
        r_flag = (r_flag & ~clr) | (m & r_mask[3:0]);
        if (ld) r_cnt = bus_wdata;
        else if (tick) r_cnt = r_cnt + 32'd1;
        if (bus_we && bus_addr == 8'h1C) r_mask = bus_wdata[11:0];
        if (bus_we && bus_addr[1:0] == 2'b00 && bus_addr < 8'h10)
            r_cmp[bus_addr[3:2]] = bus_wdata;
    endtask

    task automatic step(input logic [7:0] a, input logic we, input logic [31:0] wd,
                        input logic tk, input string tag);
        logic [31:0] exp_rd;
        bus_addr = a; bus_we = we; bus_wdata = wd; tick = tk;
        @(posedge clk);
        ref_update();
        #1;
        bus_we = 1'b0; tick = 1'b0;
        #1;
        exp_rd = ref_read(a);
        n_cmp++;
        if (irq !== r_flag || reset_req !== r_req || bus_rdata !== exp_rd) begin
            n_bad++;
            $display("FAIL %s: addr=%h rdata=%h/%h irq=%b/%b reset_req=%b/%b (actual/expected)",
                     tag, a, bus_rdata, exp_rd, irq, r_flag, reset_req, r_req);
        end
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(a, 1'b0, 32'd0, 1'b0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(a, 1'b1, d, 1'b0, tag);
    endtask

    task automatic ticks(input int n, input logic [7:0] a, input string tag);
        for (int k = 0; k < n; k++) step(a, 1'b0, 32'd0, 1'b1, tag);
    endtask

    initial begin
        rst = 1'b1;
        step(8'h10, 1'b0, 0, 1'b1, "R1");
        step(8'h10, 1'b0, 0, 1'b1, "R1");
        rst = 1'b0;
        for (int a = 0; a < 8; a++) rd(8'(a * 4), "R1");

        // R2: counting, holding
        ticks(5, 8'h10, "R2");
        rd(8'h10, "R2");
        step(8'h10, 1'b0, 0, 1'b0, "R2");
        ticks(2, 8'h10, "R2");

        // R3: load, load beats tick
        wr(8'h10, 32'd100, "R3");
        step(8'h10, 1'b1, 32'd200, 1'b1, "R3");
        ticks(2, 8'h10, "R3");

        // R4: enabled match on channel 0
        wr(8'h1C, 32'h1, "R7");
        wr(8'h00, 32'd210, "R4");
        rd(8'h00, "R4");
        ticks(10, 8'h14, "R4");
        // load landing on compare value does not match
        wr(8'h00, 32'd50, "R3");
        wr(8'h14, 32'h0, "R6");
        wr(8'h14, 32'h1, "R6");
        step(8'h10, 1'b1, 32'd50, 1'b1, "R3");
        rd(8'h14, "R3");

        // R5: masked channel 1
        wr(8'h04, 32'd53, "R5");
        ticks(4, 8'h14, "R5");

        // R7: mask width
        wr(8'h1C, 32'hFFFF_FFFF, "R7");
        rd(8'h1C, "R7");
        wr(8'h1C, 32'h0000_0007, "R7");

        // R6: clear only named bits, clear+set same cycle
        wr(8'h04, 32'd60, "R6");
        wr(8'h08, 32'd60, "R6");
        ticks(6, 8'h14, "R6");
        wr(8'h14, 32'h0000_0002, "R6");
        rd(8'h14, "R6");
        wr(8'h00, 32'd62, "R6");
        step(8'h14, 1'b1, 32'h1, 1'b1, "R6");
        step(8'h14, 1'b1, 32'hF, 1'b1, "R6");
        rd(8'h14, "R6");

        // R8: watchdog on channel 3, mask bit 3 clear
        wr(8'h18, 32'h8000_0001, "R8");
        rd(8'h18, "R8");
        wr(8'h0C, 32'd66, "R8");
        ticks(4, 8'h18, "R8");
        rd(8'h18, "R8");
        // disarmed: a second match yields no pulse
        wr(8'h0C, 32'd68, "R8");
        ticks(3, 8'h18, "R8");
        // arm bit 0 clear: no pulse
        wr(8'h18, 32'h2, "R8");
        wr(8'h0C, 32'd72, "R8");
        ticks(4, 8'h18, "R8");
        // write in the firing cycle loses to the clear
        wr(8'h18, 32'h1, "R8");
        wr(8'h0C, 32'd74, "R8");
        step(8'h18, 1'b1, 32'h5, 1'b1, "R8");
        rd(8'h18, "R8");

        // R9: wrap
        wr(8'h1C, 32'h4, "R9");
        wr(8'h08, 32'd1, "R9");
        wr(8'h10, 32'hFFFF_FFFE, "R9");
        ticks(4, 8'h14, "R9");
        rd(8'h10, "R9");

        // R10: unmapped offsets
        step(8'h20, 1'b1, 32'hDEAD_BEEF, 1'b0, "R10");
        step(8'h05, 1'b1, 32'h1234_5678, 1'b0, "R10");
        step(8'h7C, 1'b1, 32'hFFFF_FFFF, 1'b0, "R10");
        rd(8'h05, "R10");
        rd(8'h20, "R10");
        for (int a = 0; a < 8; a++) rd(8'(a * 4), "R10");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish (actual hung / expected done)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule